// File: doc/BRIEF.md
# Accumulator ALU with Masked Flag Register

This block is the arithmetic and logic core of a small 8-bit accumulator processor. Each cycle it takes the accumulator value, a second 8-bit operand and a 5-bit operation code. It works out a result byte and a write-enable for that byte. It also works out new values for four status flags: zero, subtract, half-carry and carry. A mask tells which of those four flags the operation writes.

The flags live in a register inside the block. The carry-in for the carry-using operations comes from that register. When the strobe `exec` is high at a clock edge, the flags named by the mask take their new values and the other flags keep their old ones.

The result path is purely combinational. The surrounding datapath chooses where the result goes: back into the accumulator, or into another register or memory for the single-operand shift group.

Top module: `acc_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four flags. The flags output packs them as bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C.
- R2: ADD (op 0) and ADC (op 1) return `acc + opnd` (ADC adds the stored C). H is set when the low nibbles plus carry-in exceed 15. C is set when the full sum exceeds 255. Z is set on a zero byte. N is cleared. The write-enable is 1.
- R3: SUB (op 2) and SBC (op 3) return `acc - opnd` (SBC also subtracts the stored C). N is set. H is set when the low nibble of the operand plus carry-in exceeds the low nibble of acc. C is set when the operand plus carry-in exceeds acc.
- R4: CP (op 7) produces the same four flags as SUB, but the write-enable is 0.
- R5: AND (op 4) sets H and clears N and C. XOR (op 5) and OR (op 6) clear N, H and C. All three return the bitwise result and set Z from it.
- R6: CPL (op 8) returns the inverted accumulator and sets N and H to 1. Its mask is 4'b0110, so Z and C keep their stored values.
- R7: The rotates act on `opnd`. RLC (op 9) copies bit 7 into both bit 0 and C. RRC (op 10) copies bit 0 into both bit 7 and C. RL (op 11) shifts the stored C into bit 0 and bit 7 into C. RR (op 12) shifts the stored C into bit 7 and bit 0 into C.
- R8: The shifts act on `opnd`. SLA (op 13) fills bit 0 with zero. SRA (op 14) keeps bit 7. SRL (op 15) fills bit 7 with zero. SLA puts old bit 7 into C. SRA and SRL put old bit 0 into C.
- R9: SWAP (op 16) exchanges the nibbles of `opnd`, sets Z from the value and clears N, H and C. For every operation from op 9 to op 16, N and H are 0 and Z comes from the result.
- R10: Every operation from op 0 to op 7 and from op 9 to op 16 has mask 4'b1111. Codes 17 to 31 have write-enable 0 and mask 0.
- R11: The flag register changes only when `exec` is high, and then only in the masked bits. With `exec` low, or with a mask bit at 0, that flag holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the flag register |
| exec | input | 1 | Commits the masked flags at the clock edge |
| op | input | 5 | Operation code |
| acc | input | W | Accumulator value |
| opnd | input | W | Second operand, or the source for the shift group |
| res | output | W | Result byte |
| res_we | output | 1 | Result should be written |
| flag_mask | output | 4 | Flags the current operation writes (Z,N,H,C) |
| flags | output | 4 | Stored flags (Z,N,H,C) |

## Verification
The bench builds the block with its default width of 8 and a nibble width of 4. This makes every carry, borrow and half-carry boundary reachable with hand-picked operands such as 0x0F+0x01, 0xFF+0x01 and 0x00-0x01. A stream of pseudo-random codes then walks all 32 operation codes, including the undefined ones. Because the carry-in chains from one operation to the next through the stored flags, ADC, SBC, RL and RR are exercised with both carry values, and CPL is checked to keep whatever Z and C came before it.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec,
  input  logic [4:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic [3:0]   flag_mask,
  output logic [3:0]   flags
);
  localparam int HB = W / 2;

  logic         cin;
  logic [W:0]   sum, diff;
  logic [HB:0]  hsum, hdiff;
  logic [3:0]   nf;

  assign cin = (op == 5'd1 || op == 5'd3) ? flags[0] : 1'b0;

  assign sum   = {1'b0, acc} + {1'b0, opnd} + {{W{1'b0}}, cin};
  assign diff  = {1'b0, acc} - {1'b0, opnd} - {{W{1'b0}}, cin};
  assign hsum  = {1'b0, acc[HB-1:0]} + {1'b0, opnd[HB-1:0]} + {{HB{1'b0}}, cin};
  assign hdiff = {1'b0, acc[HB-1:0]} - {1'b0, opnd[HB-1:0]} - {{HB{1'b0}}, cin};

  always_comb begin
    res       = '0;
    res_we    = 1'b1;
    flag_mask = 4'b1111;
    nf        = 4'b0000;
    case (op)
      5'd0, 5'd1: begin
        res = sum[W-1:0];
        nf  = {1'b0, 1'b0, hsum[HB], sum[W]};
      end
      5'd2, 5'd3, 5'd7: begin
        res    = diff[W-1:0];
        res_we = (op != 5'd7);
        nf     = {1'b0, 1'b1, hdiff[HB], diff[W]};
      end
      5'd4: begin res = acc & opnd; nf = 4'b0010; end
      5'd5: res = acc ^ opnd;
      6'd6: res = acc | opnd;
      5'd8: begin
        res       = ~acc;
        flag_mask = 4'b0110;
        nf        = 4'b0110;
      end
      5'd9:  begin res = {opnd[W-2:0], opnd[W-1]};  nf[0] = opnd[W-1]; end
      5'd10: begin res = {opnd[0], opnd[W-1:1]};    nf[0] = opnd[0];   end
      5'd11: begin res = {opnd[W-2:0], flags[0]};   nf[0] = opnd[W-1]; end
      5'd12: begin res = {flags[0], opnd[W-1:1]};   nf[0] = opnd[0];   end
      5'd13: begin res = {opnd[W-2:0], 1'b0};       nf[0] = opnd[W-1]; end
      5'd14: begin res = {opnd[W-1], opnd[W-1:1]};  nf[0] = opnd[0];   end
      5'd15: begin res = {1'b0, opnd[W-1:1]};       nf[0] = opnd[0];   end
      5'd16: res = {opnd[HB-1:0], opnd[W-1:HB]};
      default: begin
        res_we    = 1'b0;
        flag_mask = 4'b0000;
      end
    endcase
    if (op != 5'd8) nf[3] = (res == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)       flags <= 4'b0000;
    else if (exec) flags <= (flags & ~flag_mask) | (nf & flag_mask);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> flags == 4'b0000); // R1
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!exec || flag_mask == 4'b0000) |=> $stable(flags)); // R11
  AST_SUB_N_SET: assert property (@(posedge clk) disable iff (rst)
    (exec && (op == 5'd2 || op == 5'd3 || op == 5'd7)) |=> flags[2]); // R3
  AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op == 5'd7) |-> !res_we); // R4
  AST_CPL_KEEP_ZC: assert property (@(posedge clk) disable iff (rst)
    (exec && op == 5'd8) |=> flags[2] && flags[1] && flags[3] == $past(flags[3]) && flags[0] == $past(flags[0])); // R6
  AST_SHIFT_NH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (exec && op >= 5'd9 && op <= 5'd16) |=> !flags[2] && !flags[1]); // R9
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (exec && res_we && flag_mask[3]) |=> flags[3] == ($past(res) == '0)); // R2
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst, exec;
  logic [4:0] op;
  logic [7:0] acc, opnd;
  logic [7:0] res;
  logic       res_we;
  logic [3:0] flag_mask, flags;

  int checks = 0, errors = 0;
  logic [3:0] mflags;
  bit done = 0;

  always #4 clk = ~clk;

  acc_alu #(.W(8)) u_acc_alu (
    .clk(clk), .rst(rst), .exec(exec), .op(op), .acc(acc), .opnd(opnd),
    .res(res), .res_we(res_we), .flag_mask(flag_mask), .flags(flags)
  );

  function automatic string tag(int o);
    if (o <= 1) return "R2";
    if (o <= 3) return "R3";
    if (o == 7) return "R4";
    if (o <= 6) return "R5";
    if (o == 8) return "R6";
    if (o <= 12) return "R7";
    if (o <= 15) return "R8";
    if (o == 16) return "R9";
    return "R10";
  endfunction

  task automatic model(input int o, input int a, input int b, input logic [3:0] f,
                       output int r, output bit we, output logic [3:0] m, output logic [3:0] nf);
    int c, z, n, h, cy;
    c = f[0];
    we = 1; m = 4'hF; n = 0; h = 0; cy = 0; r = 0;
    case (o)
      0, 1: begin
        if (o == 0) c = 0;
        r = a + b + c; h = ((a % 16) + (b % 16) + c) > 15; cy = r > 255; r = r % 256;
      end
      2, 3, 7: begin
        if (o == 2 || o == 7) c = 0;
        n = 1; h = (b % 16) + c > (a % 16); cy = b + c > a; r = (a - b - c + 512) % 256;
        we = (o != 7);
      end
      4: begin r = a & b; h = 1; end
      5: r = a ^ b;
      6: r = a | b;
      8: begin r = 255 - a; m = 4'b0110; end
      9:  begin cy = b / 128; r = (b * 2) % 256 + cy; end
      10: begin cy = b % 2; r = b / 2 + cy * 128; end
      11: begin cy = b / 128; r = (b * 2) % 256 + c; end
      12: begin cy = b % 2; r = b / 2 + c * 128; end
      13: begin cy = b / 128; r = (b * 2) % 256; end
      14: begin cy = b % 2; r = b / 2 + (b / 128) * 128; end
      15: begin cy = b % 2; r = b / 2; end
      16: r = (b % 16) * 16 + b / 16;
      default: begin we = 0; m = 4'h0; end
    endcase
    z = (r == 0);
    nf = {z[0], n[0], h[0], cy[0]};
    if (o == 8) nf = {f[3], 1'b1, 1'b1, f[0]};
  endtask

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic step(input int o, input int a, input int b, input bit ex);
    int r; bit we; logic [3:0] m, nf;
    @(negedge clk);
    op = o[4:0]; acc = a[7:0]; opnd = b[7:0]; exec = ex;
    #1;
    model(o, a, b, mflags, r, we, m, nf);
    check(tag(o), "write enable", int'(res_we), int'(we));
    check(tag(o), "mask", int'(flag_mask), int'(m));
    if (we) check(tag(o), "result", int'(res), r);
    @(posedge clk);
    if (ex) mflags = (mflags & ~m) | (nf & m);
    #1;
    check(ex ? tag(o) : "R11", "flags", int'(flags), int'(mflags));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst = 1; exec = 0; op = 0; acc = 0; opnd = 0;
    repeat (2) @(posedge clk);
    #1;
    check("R1", "reset flags", int'(flags), 0);
    mflags = 4'h0;
    @(negedge clk); rst = 0;
    // R2 boundaries
    step(0, 8'h0F, 8'h01, 1); step(0, 8'hFF, 8'h01, 1); step(1, 8'h0E, 8'h01, 1);
    step(1, 8'h10, 8'hEF, 1);
    // R3 and R4
    step(2, 8'h00, 8'h01, 1); step(3, 8'h10, 8'h0F, 1); step(3, 8'h22, 8'h11, 1);
    step(7, 8'h42, 8'h42, 1); step(7, 8'h10, 8'h20, 1);
    // R5
    step(4, 8'hF0, 8'h0F, 1); step(5, 8'hAA, 8'h55, 1); step(6, 8'h00, 8'h00, 1);
    // R6 with Z=1 and C=0 kept
    step(8, 8'h5A, 8'h00, 1); step(0, 8'hFF, 8'h01, 1); step(8, 8'hFF, 8'h00, 1);
    // R7 R8 R9
    step(9, 0, 8'h80, 1); step(10, 0, 8'h01, 1); step(11, 0, 8'h40, 1); step(11, 0, 8'h80, 1);
    step(12, 0, 8'h01, 1); step(12, 0, 8'h02, 1); step(13, 0, 8'h80, 1); step(14, 0, 8'h81, 1);
    step(15, 0, 8'h81, 1); step(16, 0, 8'h3C, 1); step(16, 0, 8'h00, 1);
    // R10 and R11
    step(17, 8'h12, 8'h34, 1); step(31, 8'h00, 8'h00, 1); step(2, 8'h00, 8'h01, 0);
    lf = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(int'(lf[4:0]), int'(lf[12:5]), int'(lf[15:8] ^ lf[7:0]), lf[3] | lf[9]);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule